// File: doc/BRIEF.md
# Selectable Line-Code Encoder with Echo and Loopback Routing

This block converts a transmit bit stream into a line waveform. At run time a two-bit mode input selects one of four codes: plain level coding, transition-on-zero coding, or one of two biphase codes. Each biphase code has a transition at every cell edge and marks one of the two bit values with a transition in mid-cell. The block is clocked by the system clock. A clock enable (`halfEn`) pulses at twice the bit rate, and each pulse marks one half of a bit cell. The first pulse of each pair opens a cell. On that pulse the block captures the data bit and the mode.

Routing between the line pins and the receive side is built into the block. With echo on, whatever arrives on the line input goes straight back out on the line output. With loopback on, the encoded waveform feeds the receive-side data output and the external line output rests at the idle marking level. Decoding and clock recovery belong to the logic that consumes `rxData`.

Top module: `line_encoder`

## Requirements
- R1: After reset the encoded level is 1 (marking) and the next `halfEn` pulse opens a bit cell. After that, `halfEn` pulses alternate between cell start and mid-cell.
- R2: Mode 2'b00 (level coding): for the whole cell the encoded level equals the data bit captured at cell start.
- R3: Mode 2'b01: at cell start the level stays the same for a 1 bit and inverts for a 0 bit. It never changes at mid-cell.
- R4: Mode 2'b10: the level inverts at every cell start and inverts again at mid-cell when the captured bit is 1.
- R5: Mode 2'b11: the level inverts at every cell start and inverts again at mid-cell when the captured bit is 0.
- R6: The block samples the mode and the data bit only on the cell-start pulse. Changes made during a cell take effect at the next cell.
- R7: While `halfEn` is low the encoded level does not change.
- R8: With `echoEn`=1 and `loopEn`=0, `lineOut` equals `rxLineIn` combinationally.
- R9: With `loopEn`=1, `lineOut` is held at 1 and `rxData` carries the encoded level. `loopEn` takes priority over `echoEn`.
- R10: With `loopEn`=0, `rxData` equals `rxLineIn`. With both controls at 0, `lineOut` carries the encoded level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| halfEn | input | 1 | Half-bit-cell clock enable (2x bit rate) |
| txBit | input | 1 | Transmit data bit, captured at cell start |
| mode | input | 2 | Line code select: 00 level, 01 toggle-on-0, 10 biphase mark-1, 11 biphase mark-0 |
| echoEn | input | 1 | Send line input back out on line output |
| loopEn | input | 1 | Route encoded data to receive side, idle the line |
| rxLineIn | input | 1 | Received line input |
| lineOut | output | 1 | Line output |
| rxData | output | 1 | Data presented to the receive side |

## Verification
A half-cell phase that has slipped by one pulse swaps the start and mid-cell roles. The first biphase cell then shows its transitions in the wrong halves, one `halfEn` pulse after the error. A wrong held level in the toggle code inverts every later half-cell, so it appears on the very next sample. Mode or data captured at the wrong moment shows up at the next mid-cell pulse. That is why the bench changes both inputs inside a cell and checks the level half a cell later.

// File: rtl/line_enc_pkg.sv
package line_enc_pkg;

  typedef enum logic [1:0] {
    LM_LEVEL  = 2'b00,
    LM_TOGGLE = 2'b01,
    LM_MARK1  = 2'b10,
    LM_MARK0  = 2'b11
  } line_mode_e;

  localparam logic IDLE_LEVEL = 1'b1;

  typedef struct packed {
    logic cellStart;
    logic midCell;
  } cell_strobe_t;

endpackage

// File: rtl/line_enc_ctrl.sv
module line_enc_ctrl
  import line_enc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         halfEn,
  output cell_strobe_t strb
);

  logic secondHalf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secondHalf <= 1'b0;
    end else if (halfEn) begin
      secondHalf <= ~secondHalf;
    end
  end

  always_comb begin
    strb.cellStart = halfEn & ~secondHalf;
    strb.midCell   = halfEn & secondHalf;
  end

endmodule

// File: rtl/line_enc_dp.sv
module line_enc_dp
  import line_enc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  cell_strobe_t strb,
  input  logic         txBit,
  input  logic [1:0]   mode,
  output logic         encLvl
);

  line_mode_e curMode;
  logic       curBit;
  logic       startLvl;
  logic       midLvl;

  always_comb begin
    case (line_mode_e'(mode))
      LM_LEVEL:  startLvl = txBit;
      LM_TOGGLE: startLvl = txBit ? encLvl : ~encLvl;
      default:   startLvl = ~encLvl;
    endcase
  end

  always_comb begin
    case (curMode)
      LM_MARK1: midLvl = encLvl ^ curBit;
      LM_MARK0: midLvl = encLvl ^ ~curBit;
      default:  midLvl = encLvl;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encLvl  <= IDLE_LEVEL;
      curMode <= LM_LEVEL;
      curBit  <= IDLE_LEVEL;
    end else if (strb.cellStart) begin
      encLvl  <= startLvl;
      curMode <= line_mode_e'(mode);
      curBit  <= txBit;
    end else if (strb.midCell) begin
      encLvl  <= midLvl;
    end
  end

endmodule

// File: rtl/line_enc_route.sv
module line_enc_route
  import line_enc_pkg::*;
(
  input  logic encLvl,
  input  logic echoEn,
  input  logic loopEn,
  input  logic rxLineIn,
  output logic lineOut,
  output logic rxData
);

  always_comb begin
    if (loopEn) begin
      lineOut = IDLE_LEVEL;
      rxData  = encLvl;
    end else begin
      lineOut = echoEn ? rxLineIn : encLvl;
      rxData  = rxLineIn;
    end
  end

endmodule

// File: rtl/line_encoder.sv
module line_encoder
  import line_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       halfEn,
  input  logic       txBit,
  input  logic [1:0] mode,
  input  logic       echoEn,
  input  logic       loopEn,
  input  logic       rxLineIn,
  output logic       lineOut,
  output logic       rxData
);

  cell_strobe_t strb;
  logic         encLvl;

  line_enc_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .halfEn (halfEn),
    .strb   (strb)
  );

  line_enc_dp i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .txBit  (txBit),
    .mode   (mode),
    .encLvl (encLvl)
  );

  line_enc_route i_route (
    .encLvl   (encLvl),
    .echoEn   (echoEn),
    .loopEn   (loopEn),
    .rxLineIn (rxLineIn),
    .lineOut  (lineOut),
    .rxData   (rxData)
  );

endmodule

// File: rtl/line_encoder_chk.sv
module line_encoder_chk
  import line_enc_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         halfEn,
  input logic         txBit,
  input logic [1:0]   mode,
  input logic         echoEn,
  input logic         loopEn,
  input logic         rxLineIn,
  input logic         lineOut,
  input logic         rxData,
  input cell_strobe_t strb,
  input logic         encLvl
);

  // R7
  hold_no_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !halfEn |=> $stable(encLvl));

  // R2
  level_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cellStart && mode == LM_LEVEL) |=> (encLvl == $past(txBit)));

  // R4
  biphase_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cellStart && mode[1]) |=> (encLvl != $past(encLvl)));

  // R3
  toggle_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cellStart && mode == LM_TOGGLE && txBit) |=> $stable(encLvl));

  // R8
  echo_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (echoEn && !loopEn) |-> (lineOut == rxLineIn));

  // R9
  loop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    loopEn |-> (lineOut && (rxData == encLvl)));

endmodule

bind line_encoder line_encoder_chk i_chk (.*);

// File: tb/test_line_encoder.sv
`timescale 1ns/1ps
module test_line_encoder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       halfEn = 1'b0;
  logic       txBit = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       echoEn = 1'b0;
  logic       loopEn = 1'b0;
  logic       rxLineIn = 1'b0;
  logic       lineOut;
  logic       rxData;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  line_encoder i_line_encoder (
    .clk(clk), .rstN(rstN), .halfEn(halfEn), .txBit(txBit), .mode(mode),
    .echoEn(echoEn), .loopEn(loopEn), .rxLineIn(rxLineIn),
    .lineOut(lineOut), .rxData(rxData)
  );

  // {mode[1:0], bits[3:0] first bit MSB, expected half-cell levels[7:0] first MSB}
  localparam logic [13:0] VECS [8] = '{
    {2'b00, 4'b1011, 8'hCF},
    {2'b00, 4'b0000, 8'h00},
    {2'b01, 4'b1011, 8'hC0},
    {2'b01, 4'b0000, 8'h33},
    {2'b10, 4'b1011, 8'h4A},
    {2'b10, 4'b0000, 8'h33},
    {2'b11, 4'b1011, 8'h2C},
    {2'b11, 4'b0000, 8'h55}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    halfEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic halfStep();
    @(negedge clk);
    halfEn = 1'b1;
    @(negedge clk);
    halfEn = 1'b0;
  endtask

  function automatic string reqOf(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] seq;
    logic [7:0] lineSeq;
    logic       held;

    // R1 reset state, R10 receive path
    doReset();
    @(negedge clk);
    check("R1", {7'd0, lineOut}, 8'd1);
    check("R10", {7'd0, rxData}, 8'd0);

    // R2 R3 R4 R5: table walk; R1 first pulse opens a cell
    for (int v = 0; v < 8; v++) begin
      mode = VECS[v][13:12];
      doReset();
      seq = '0;
      for (int b = 0; b < 4; b++) begin
        txBit = VECS[v][11-b];
        halfStep();
        seq[7-2*b] = lineOut;
        halfStep();
        seq[6-2*b] = lineOut;
      end
      check(reqOf(VECS[v][13:12]), seq, VECS[v][7:0]);
    end

    // R7: no enable, level holds while data and mode move
    held = lineOut;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      txBit = ~txBit;
      mode = mode + 2'd1;
    end
    @(negedge clk);
    check("R7", {7'd0, lineOut}, {7'd0, held});

    // R6: mode change inside a cell waits for the next cell
    mode = 2'b00;
    doReset();
    txBit = 1'b1;
    halfStep();
    mode = 2'b10;
    halfStep();
    check("R6", {7'd0, lineOut}, 8'd1);
    halfStep();
    check("R6", {7'd0, lineOut}, 8'd0);

    // R6: data change inside a biphase cell is ignored until the next cell
    mode = 2'b10;
    doReset();
    txBit = 1'b1;
    halfStep();
    txBit = 1'b0;
    halfStep();
    check("R6", {7'd0, lineOut}, 8'd1);

    // R8: echo follows line input
    doReset();
    echoEn = 1'b1;
    rxLineIn = 1'b0;
    #1;
    check("R8", {7'd0, lineOut}, 8'd0);
    rxLineIn = 1'b1;
    #1;
    check("R8", {7'd0, lineOut}, 8'd1);
    echoEn = 1'b0;

    // R9: loopback, encoded data on receive side, line idle, priority over echo
    mode = 2'b10;
    doReset();
    loopEn = 1'b1;
    echoEn = 1'b1;
    rxLineIn = 1'b0;
    seq = '0;
    lineSeq = '0;
    for (int b = 0; b < 4; b++) begin
      txBit = VECS[4][11-b];
      halfStep();
      seq[7-2*b] = rxData;
      lineSeq[7-2*b] = lineOut;
      halfStep();
      seq[6-2*b] = rxData;
      lineSeq[6-2*b] = lineOut;
    end
    check("R9", seq, 8'h4A);
    check("R9", lineSeq, 8'hFF);

    // R10: with loopback off, receive side follows line input and line carries encoded level
    loopEn = 1'b0;
    echoEn = 1'b0;
    rxLineIn = 1'b1;
    #1;
    check("R10", {7'd0, rxData}, 8'd1);
    check("R10", {7'd0, lineOut}, 8'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule